// File: doc/BRIEF.md
# Bitfield and Byte-Swap Unit

This block is a purely combinational datapath for bit-manipulation instructions in a 64-bit integer pipeline. An operation code selects one of six functions: field extract, field insert, a byte exchange inside every 16-bit lane, a halfword exchange inside every 32-bit word, and sign extension of the lowest byte or the lowest halfword. The functions draw on a source operand, a destination operand that only insert reads, a 6-bit position and a 6-bit size.

A mode flag selects 32-bit behaviour. In that mode, extract and insert see only the low 32 bits of the source. For extract, insert and both swap operations, the result is sign-extended from bit 31 into the upper word. The unit does not check whether a position and size pair is legal. The result for any pair follows the mask arithmetic set out in the requirements.

Top module: `bitfield_swap_unit`

## Requirements
- R1: Operation codes on `opCode` are 0 extract, 1 insert, 2 byte exchange per halfword, 3 halfword exchange per word, 4 sign-extend byte, 5 sign-extend halfword. Codes 6 and 7 drive a result of zero.
- R2: Extract returns the source shifted right by `fieldPos`, ANDed with a mask of `fieldSize` low ones. A size of 0 gives zero.
- R3: For extract and insert, a `fieldSize` of 32 or more turns the unshifted mask into all ones.
- R4: Insert forms its mask by shifting the low-ones mask left by `fieldPos`, with bits past bit 63 dropped. Result bits inside the mask come from the source shifted left by `fieldPos`. All other result bits equal `dstVal`.
- R5: With `mode32` high, extract and insert ignore source bits 63:32 and treat them as zero.
- R6: Byte exchange swaps bits 7:0 and 15:8 of each of the four 16-bit lanes.
- R7: Halfword exchange swaps bits 15:0 and 31:16 of each of the two 32-bit words.
- R8: Sign-extend byte copies source bit 7 into result bits 63:8 and ignores source bits 63:8.
- R9: Sign-extend halfword copies source bit 15 into result bits 63:16 and ignores source bits 63:16.
- R10: With `mode32` high and codes 0 to 3, result bits 63:32 all equal result bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 3 | Operation select |
| mode32 | input | 1 | 32-bit operating mode |
| srcVal | input | 64 | Source operand |
| dstVal | input | 64 | Destination operand, read by insert only |
| fieldPos | input | 6 | Bit position of the field |
| fieldSize | input | 6 | Width of the field in bits |
| resultVal | output | 64 | Operation result |

## Verification
Some properties are checked every time the inputs settle. These are: zero output for the two spare codes, at most one active function strobe, the narrow-source strobe only on field operations, and sign replication into the upper word in 32-bit mode. Also checked each time are zero output from an empty extract, the low byte and upper copy of sign-extend byte, and the insert rule that bits outside the mask equal the destination. The exact field contents are checked only by the bench scenarios, against a bit-by-bit model. These include masks truncated at bit 63, the saturation of sizes 32 and above, and lane ordering for both swaps.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [2:0] {
    OP_EXTRACT     = 3'd0,
    OP_INSERT      = 3'd1,
    OP_BSWAP_HALF  = 3'd2,
    OP_SWAP_HALVES = 3'd3,
    OP_SEXT_BYTE   = 3'd4,
    OP_SEXT_HALF   = 3'd5
  } bfuOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doExtract;
    logic doInsert;
    logic doByteSwap;
    logic doHalfSwap;
    logic doSextByte;
    logic doSextHalf;
    logic narrowSrc;
    logic narrowResult;
  } bfuStrobes_t;

endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic [2:0]  opCode,
  input  logic        mode32,
  output bfuStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    case (opCode)
      OP_EXTRACT: begin
        strobes.doExtract    = 1'b1;
        strobes.narrowSrc    = mode32;
        strobes.narrowResult = mode32;
      end
      OP_INSERT: begin
        strobes.doInsert     = 1'b1;
        strobes.narrowSrc    = mode32;
        strobes.narrowResult = mode32;
      end
      OP_BSWAP_HALF: begin
        strobes.doByteSwap   = 1'b1;
        strobes.narrowResult = mode32;
      end
      OP_SWAP_HALVES: begin
        strobes.doHalfSwap   = 1'b1;
        strobes.narrowResult = mode32;
      end
      OP_SEXT_BYTE: strobes.doSextByte = 1'b1;
      OP_SEXT_HALF: strobes.doSextHalf = 1'b1;
      default: strobes = '0;
    endcase
  end

  // R1: at most one function strobe per operation
  always_comb begin
    if (!$isunknown(opCode)) begin
      assert_onehot_func_R1: assert ($onehot0({strobes.doExtract, strobes.doInsert,
          strobes.doByteSwap, strobes.doHalfSwap, strobes.doSextByte, strobes.doSextHalf}))
        else $error("function strobes not one-hot");
    end
  end

  // R5: the narrow-source strobe belongs to field operations only
  always_comb begin
    if (!$isunknown({opCode, mode32})) begin
      assert_narrow_src_R5: assert (!strobes.narrowSrc || (mode32 && opCode <= 3'd1))
        else $error("narrow source strobe outside field ops");
    end
  end

endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int FIELD_W  = 6,
  parameter int NARROW_W = 32
) (
  input  bfuStrobes_t         strobes,
  input  logic [DATA_W-1:0]   srcVal,
  input  logic [DATA_W-1:0]   dstVal,
  input  logic [FIELD_W-1:0]  posVal,
  input  logic [FIELD_W-1:0]  sizeVal,
  output logic [DATA_W-1:0]   resultVal
);

  localparam int NUM_HALF  = DATA_W / 16;
  localparam int NUM_WORD  = DATA_W / 32;
  localparam int UPPER_W   = DATA_W - NARROW_W;
  localparam logic [FIELD_W-1:0] SAT_SIZE = FIELD_W'(NARROW_W);

  logic [DATA_W-1:0] srcEff;
  logic [DATA_W-1:0] lowMask;
  logic [DATA_W-1:0] insMask;
  logic [DATA_W-1:0] extractVal;
  logic [DATA_W-1:0] insertVal;
  logic [DATA_W-1:0] byteSwapped;
  logic [DATA_W-1:0] halfSwapped;
  logic [DATA_W-1:0] sextByte;
  logic [DATA_W-1:0] sextHalf;
  logic [DATA_W-1:0] rawResult;

  // source seen by field ops; upper word cleared in narrow mode
  assign srcEff = strobes.narrowSrc ? {{UPPER_W{1'b0}}, srcVal[NARROW_W-1:0]} : srcVal;

  // field mask: saturates to all ones at the narrow width
  assign lowMask = (sizeVal >= SAT_SIZE) ? {DATA_W{1'b1}}
                                         : ((DATA_W'(1) << sizeVal) - DATA_W'(1));
  assign insMask = lowMask << posVal;

  assign extractVal = (srcEff >> posVal) & lowMask;
  assign insertVal  = (dstVal & ~insMask) | ((srcEff << posVal) & insMask);

  genvar h;
  generate
    for (h = 0; h < NUM_HALF; h++) begin : g_halfLane
      assign byteSwapped[h*16 +: 16] = {srcVal[h*16 +: 8], srcVal[h*16+8 +: 8]};
    end
  endgenerate

  genvar w;
  generate
    for (w = 0; w < NUM_WORD; w++) begin : g_wordLane
      assign halfSwapped[w*32 +: 32] = {srcVal[w*32 +: 16], srcVal[w*32+16 +: 16]};
    end
  endgenerate

  assign sextByte = {{(DATA_W-8){srcVal[7]}}, srcVal[7:0]};
  assign sextHalf = {{(DATA_W-16){srcVal[15]}}, srcVal[15:0]};

  always_comb begin
    rawResult = '0;
    if (strobes.doExtract)  rawResult = rawResult | extractVal;
    if (strobes.doInsert)   rawResult = rawResult | insertVal;
    if (strobes.doByteSwap) rawResult = rawResult | byteSwapped;
    if (strobes.doHalfSwap) rawResult = rawResult | halfSwapped;
    if (strobes.doSextByte) rawResult = rawResult | sextByte;
    if (strobes.doSextHalf) rawResult = rawResult | sextHalf;
  end

  assign resultVal = strobes.narrowResult
                   ? {{UPPER_W{rawResult[NARROW_W-1]}}, rawResult[NARROW_W-1:0]}
                   : rawResult;

  // R4: outside the mask the destination survives unchanged
  always_comb begin
    if (!$isunknown({strobes, srcVal, dstVal, posVal, sizeVal})) begin
      assert_insert_keep_R4: assert (!(strobes.doInsert && !strobes.narrowResult)
                                     || (((resultVal ^ dstVal) & ~insMask) == '0))
        else $error("insert disturbed bits outside field");
    end
  end

  // R2: an empty field extracts zero
  always_comb begin
    if (!$isunknown({strobes, srcVal, posVal, sizeVal})) begin
      assert_empty_extract_R2: assert (!(strobes.doExtract && sizeVal == '0) || resultVal == '0)
        else $error("size zero extract not zero");
    end
  end

  // R8: byte sign extension keeps the low byte and replicates bit 7
  always_comb begin
    if (!$isunknown({strobes, srcVal})) begin
      assert_sext_byte_R8: assert (!strobes.doSextByte ||
          (resultVal[7:0] == srcVal[7:0] &&
           (resultVal[DATA_W-1:8] == '0 || resultVal[DATA_W-1:8] == '1) &&
           resultVal[DATA_W-1] == srcVal[7]))
        else $error("byte sign extension wrong");
    end
  end

endmodule

// File: rtl/bitfield_swap_unit.sv
module bitfield_swap_unit
  import bfu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int FIELD_W  = 6,
  parameter int NARROW_W = 32
) (
  input  logic [2:0]         opCode,
  input  logic               mode32,
  input  logic [DATA_W-1:0]  srcVal,
  input  logic [DATA_W-1:0]  dstVal,
  input  logic [FIELD_W-1:0] fieldPos,
  input  logic [FIELD_W-1:0] fieldSize,
  output logic [DATA_W-1:0]  resultVal
);

  bfuStrobes_t strobes;

  bfu_ctrl ctrl_i (
    .opCode  (opCode),
    .mode32  (mode32),
    .strobes (strobes)
  );

  bfu_datapath #(
    .DATA_W   (DATA_W),
    .FIELD_W  (FIELD_W),
    .NARROW_W (NARROW_W)
  ) datapath_i (
    .strobes   (strobes),
    .srcVal    (srcVal),
    .dstVal    (dstVal),
    .posVal    (fieldPos),
    .sizeVal   (fieldSize),
    .resultVal (resultVal)
  );

  // R1: spare codes yield zero
  always_comb begin
    if (!$isunknown(opCode)) begin
      assert_spare_zero_R1: assert (opCode <= 3'd5 || resultVal == '0)
        else $error("spare code result not zero");
    end
  end

  // R10: narrow mode replicates bit 31 upward
  always_comb begin
    if (!$isunknown({opCode, mode32, srcVal, dstVal, fieldPos, fieldSize})) begin
      assert_narrow_sign_R10: assert (!(mode32 && opCode <= 3'd3) ||
          resultVal[DATA_W-1:NARROW_W] == {(DATA_W-NARROW_W){resultVal[NARROW_W-1]}})
        else $error("narrow result not sign extended");
    end
  end

endmodule

// File: tb/bitfield_swap_unit_tb_top.sv
`timescale 1ns/1ps
module bitfield_swap_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  opCode = '0;
  logic        mode32 = 1'b0;
  logic [63:0] srcVal = '0;
  logic [63:0] dstVal = '0;
  logic [5:0]  fieldPos = '0;
  logic [5:0]  fieldSize = '0;
  logic [63:0] resultVal;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bitfield_swap_unit dut_i (
    .opCode(opCode), .mode32(mode32), .srcVal(srcVal), .dstVal(dstVal),
    .fieldPos(fieldPos), .fieldSize(fieldSize), .resultVal(resultVal)
  );

  // bit-level behavioural reference
  function automatic logic [63:0] refModel(input int op, input logic [63:0] s,
      input logic [63:0] d, input int p, input int sz, input bit narrow);
    logic [63:0] r;
    logic [63:0] sv;
    bit inField;
    r = '0;
    sv = s;
    if (narrow && op <= 1) sv[63:32] = '0;
    case (op)
      0: for (int i = 0; i < 64; i++)
           if ((sz >= 32 || i < sz) && (i + p) < 64) r[i] = sv[i+p];
      1: for (int i = 0; i < 64; i++) begin
           inField = (i >= p) && (sz >= 32 || (i - p) < sz);
           r[i] = inField ? sv[i-p] : d[i];
         end
      2: for (int l = 0; l < 4; l++)
           for (int b = 0; b < 8; b++) begin
             r[l*16+b]   = s[l*16+8+b];
             r[l*16+8+b] = s[l*16+b];
           end
      3: for (int k = 0; k < 2; k++)
           for (int b = 0; b < 16; b++) begin
             r[k*32+b]    = s[k*32+16+b];
             r[k*32+16+b] = s[k*32+b];
           end
      4: for (int i = 0; i < 64; i++) r[i] = (i < 8) ? s[i] : s[7];
      5: for (int i = 0; i < 64; i++) r[i] = (i < 16) ? s[i] : s[15];
      default: r = '0;
    endcase
    if (narrow && op <= 3)
      for (int i = 32; i < 64; i++) r[i] = r[31];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input int op, input logic [63:0] s,
      input logic [63:0] d, input int p, input int sz, input bit narrow);
    @(posedge clk);
    opCode <= 3'(op); srcVal <= s; dstVal <= d;
    fieldPos <= 6'(p); fieldSize <= 6'(sz); mode32 <= narrow;
    @(negedge clk);
    check(req, resultVal, refModel(op, s, d, p, sz, narrow));
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset all-zero inputs", resultVal, 64'h0);
    rst = 1'b0;

    // R2 extract, including hand value and empty field
    apply("R2 extract pos8 size12", 0, 64'h0123_4567_89AB_CDEF, 64'h0, 8, 12, 0);
    check("R2 extract hand value", resultVal, 64'h0000_0000_0000_0BCD);
    apply("R2 extract size0", 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3, 0, 0);
    // R3 saturation for extract and insert
    apply("R3 extract size40", 0, 64'hF0E1_D2C3_B4A5_9687, 64'h0, 4, 40, 0);
    check("R3 extract size40 hand", resultVal, 64'h0F0E_1D2C_3B4A_5968);
    apply("R3 insert size32 pos16", 1, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 16, 32, 0);
    // R4 insert merge, truncated at bit 63
    apply("R4 insert pos60 size8", 1, 64'h0000_0000_0000_005A, 64'h0123_4567_89AB_CDEF, 60, 8, 0);
    check("R4 insert hand", resultVal, 64'hA123_4567_89AB_CDEF);
    apply("R4 insert pos4 size8", 1, 64'hFFFF_FFFF_FFFF_FF3C, 64'h0, 4, 8, 0);
    check("R4 insert pos4 hand", resultVal, 64'h0000_0000_0000_03C0);
    // R5 narrow source ignores upper word
    apply("R5 narrow extract", 0, 64'hDEAD_BEEF_0000_0010, 64'h0, 4, 40, 1);
    check("R5 narrow extract hand", resultVal, 64'h0000_0000_0000_0001);
    apply("R5 narrow insert", 1, 64'hFFFF_FFFF_0000_0000, 64'h0, 32, 8, 1);
    // R6 / R7 swaps
    apply("R6 byte swap", 2, 64'h0011_2233_4455_6677, 64'h0, 0, 0, 0);
    check("R6 byte swap hand", resultVal, 64'h1100_3322_5544_7766);
    apply("R7 half swap", 3, 64'h0011_2233_4455_6677, 64'h0, 0, 0, 0);
    check("R7 half swap hand", resultVal, 64'h2233_0011_6677_4455);
    // R8 / R9 sign extension
    apply("R8 sext byte neg", 4, 64'h1234_5678_9ABC_DE80, 64'h0, 0, 0, 0);
    check("R8 sext byte hand", resultVal, 64'hFFFF_FFFF_FFFF_FF80);
    apply("R8 sext byte pos", 4, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0, 0, 0, 0);
    apply("R9 sext half", 5, 64'h0000_0000_0001_8001, 64'h0, 0, 0, 0);
    check("R9 sext half hand", resultVal, 64'hFFFF_FFFF_FFFF_8001);
    // R10 narrow sign replication
    apply("R10 narrow byte swap", 2, 64'h0000_0000_0080_0000, 64'h0, 0, 0, 1);
    check("R10 narrow byte swap hand", resultVal, 64'hFFFF_FFFF_8000_0000);
    apply("R10 narrow half swap", 3, 64'h1234_5678_FFFF_0000, 64'h0, 0, 0, 1);
    // R1 spare codes
    apply("R1 spare code 6", 6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5, 5, 0);
    apply("R1 spare code 7", 7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5, 5, 1);

    // mixed vectors across all codes and modes (R1..R10)
    for (int n = 0; n < 400; n++) begin
      apply("R4 mixed vector", int'($urandom_range(0, 7)),
            {$urandom, $urandom}, {$urandom, $urandom},
            int'($urandom_range(0, 63)), int'($urandom_range(0, 63)),
            bit'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule